// File: doc/BRIEF.md
# Host-Fed Monochrome Colour Expander

This block turns a one-bit-per-pixel bitmap into coloured pixels inside a rectangle of a frame buffer. The host pushes the bitmap as 16-bit words into a small data FIFO. The engine pulls them out and, for each bit, emits a pixel write: a set bit gives the foreground colour, and a clear bit gives the background colour. In transparent mode a clear bit gives no write at all, so the existing destination pixel is kept.

Software sets up the rectangle on the input ports: base address, line pitch, width minus one, height minus one, the bit where the first pixel sits, both colours and the mode. It then pulses `start`. While the job runs, software reads the status byte to decide how many words it may push. Every destination line begins with a fresh source word, and any bits left over at the end of a line are thrown away. The engine never reads memory. It only emits pixel writes, at most one per clock.

Top module: `mono_expand`

## Requirements
- R1: After reset the status byte reads 8'h00, `px_we` is low and the FIFO is empty.
- R2: The data FIFO holds 16 words of 16 bits, filled by `data_we`/`data_in`. Status bit 6 is 1 exactly when the FIFO holds at least one word.
- R3: Status bit 5 is 1 when the FIFO holds 8 or more words, and status bit 4 is 1 when it holds 16. Bits 5:4 therefore read 2'b00 below half, 2'b10 from half up to one short of full, and 2'b11 when full.
- R4: A data write while the FIFO is full is dropped and sets the sticky overflow flag on status bit 3. Only reset or an accepted `start` clears that flag.
- R5: Pixels are taken from each word low byte first, and within a byte from bit 7 down to bit 0. The first pixel of every line sits in the byte chosen by `start_hi` (0 = low byte), at bit `start_bit`. This gives a pixel offset of 8*`start_hi` + 7 - `start_bit` within the word.
- R6: Each line uses (offset + width + 15)/16 source words. The next line always starts with a new word at the same offset, and leftover bits are discarded.
- R7: The pixel at row r, column c is written to address `dst_base` + r*`dst_stride` + c, with arithmetic modulo 2^AW.
- R8: When `transp` is 0, every pixel of the rectangle is written: a bit of 1 gives `fg_color` and a bit of 0 gives `bg_color`.
- R9: When `transp` is 1, only the 1 bits give writes, each with `fg_color`. Destination pixels under 0 bits are left untouched.
- R10: Status bit 7 (busy) is 1 from the clock edge that accepts `start` until the cycle after the last pixel of the rectangle is presented. No pixel write occurs while busy is 0.
- R11: A `start` pulse while busy is ignored. The running job completes with its own geometry and colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse; it latches the job settings when the engine is idle |
| transp | input | 1 | 1 = transparent mode, 0 = opaque mode |
| start_hi | input | 1 | Byte of the word that holds the first pixel of each line |
| start_bit | input | 3 | Bit index of the first pixel within that byte |
| dst_base | input | AW | Address of the top-left pixel |
| dst_stride | input | AW | Address step from one line to the next |
| width_m1 | input | DIM_W | Rectangle width minus one |
| height_m1 | input | DIM_W | Rectangle height minus one |
| fg_color | input | PIX_W | Colour for 1 bits |
| bg_color | input | PIX_W | Colour for 0 bits in opaque mode |
| data_we | input | 1 | Host bitmap word write strobe |
| data_in | input | 16 | Host bitmap word |
| status | output | 8 | {busy, not-empty, half, full, overflow, 3'b000} |
| px_we | output | 1 | Pixel write strobe |
| px_addr | output | AW | Pixel write address |
| px_data | output | PIX_W | Pixel write colour |

## Verification
The assertions take for granted that the geometry inputs hold steady only around the accepted `start`, since they are latched there. They also assume the host may still write into a full FIFO, because that case is a defined drop and is not excluded. The stimulus reads the status byte every cycle and offers a word only while bit 4 is clear. It pushes a seventeenth word into a full FIFO on purpose, but only while the engine is idle, so that the dropped word and the sticky flag can both be observed. Random jobs keep the line pitch larger than the width, so rectangles never overlap themselves. A job that is started again while it runs is made large enough that it cannot have finished before the second pulse.

// File: rtl/mxp_pkg.sv
package mxp_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned POS_W   = 4;
  localparam int unsigned ST_BUSY = 7;
  localparam int unsigned ST_NEMP = 6;
  localparam int unsigned ST_HALF = 5;
  localparam int unsigned ST_FULL = 4;
  localparam int unsigned ST_OVF  = 3;

  // pixel position within a word -> bit index (low byte first, MSB first in a byte)
  function automatic logic [POS_W-1:0] word_bit(input logic [POS_W-1:0] p);
    return {p[3], ~p[2:0]};
  endfunction
endpackage

// File: rtl/mxp_fifo.sv
module mxp_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  input  logic         clr_ovf,
  output logic         nempty,
  output logic         half,
  output logic         full,
  output logic         ovf
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             push_ok, pop_ok;

  always_comb begin
    full    = (cnt_q == CNT_W'(DEPTH));
    half    = (cnt_q >= CNT_W'(DEPTH / 2));
    nempty  = (cnt_q != '0);
    push_ok = push && !full;
    pop_ok  = pop && nempty;
    wptr_d  = wptr_q + PTR_W'(push_ok);
    rptr_d  = rptr_q + PTR_W'(pop_ok);
    cnt_d   = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    ovf_d   = (ovf_q && !clr_ovf) || (push && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign ovf   = ovf_q;

  // a write into a full FIFO with no pop leaves the fill level unchanged
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
  assert_full_from_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(push));
endmodule

// File: rtl/mxp_seq.sv
module mxp_seq
  import mxp_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DIM_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic [POS_W-1:0]  off_in,
  input  logic [DIM_W-1:0]  wm1_in,
  input  logic [DIM_W-1:0]  hm1_in,
  input  logic [AW-1:0]     base_in,
  input  logic [AW-1:0]     stride_in,
  input  logic              fifo_nempty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              pop,
  output logic              emit,
  output logic              pix_bit,
  output logic [AW-1:0]     pix_addr,
  output logic              run
);
  logic              run_q, run_d, wv_q, wv_d;
  logic [WORD_W-1:0] wbuf_q, wbuf_d;
  logic [POS_W-1:0]  pos_q, pos_d, off_q;
  logic [DIM_W-1:0]  col_q, col_d, row_q, row_d, wm1_q, hm1_q;
  logic [AW-1:0]     line_q, line_d, stride_q;
  logic              col_end, last, drop;

  always_comb begin
    emit    = run_q && wv_q;
    col_end = (col_q == wm1_q);
    last    = col_end && (row_q == hm1_q);
    drop    = emit && ((pos_q == '1) || col_end);
    pop     = run_q && fifo_nempty && (!wv_q || drop) && !(emit && last);
    pix_bit = wbuf_q[word_bit(pos_q)];
    pix_addr = line_q + AW'(col_q);
  end

  always_comb begin
    run_d  = run_q;
    wv_d   = wv_q;
    wbuf_d = wbuf_q;
    pos_d  = pos_q;
    col_d  = col_q;
    row_d  = row_q;
    line_d = line_q;
    if (start_acc) begin
      run_d  = 1'b1;
      wv_d   = 1'b0;
      pos_d  = off_in;
      col_d  = '0;
      row_d  = '0;
      line_d = base_in;
    end else if (run_q) begin
      if (emit) begin
        if (col_end) begin
          col_d = '0;
          pos_d = off_q;
          if (last) begin
            run_d = 1'b0;
          end else begin
            row_d  = row_q + DIM_W'(1);
            line_d = line_q + stride_q;
          end
        end else begin
          col_d = col_q + DIM_W'(1);
          pos_d = pos_q + POS_W'(1);
        end
      end
      if (pop) begin
        wv_d   = 1'b1;
        wbuf_d = fifo_rdata;
      end else if (drop) begin
        wv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wv_q     <= 1'b0;
      wbuf_q   <= '0;
      pos_q    <= '0;
      col_q    <= '0;
      row_q    <= '0;
      line_q   <= '0;
      off_q    <= '0;
      wm1_q    <= '0;
      hm1_q    <= '0;
      stride_q <= '0;
    end else begin
      run_q  <= run_d;
      wv_q   <= wv_d;
      wbuf_q <= wbuf_d;
      pos_q  <= pos_d;
      col_q  <= col_d;
      row_q  <= row_d;
      line_q <= line_d;
      if (start_acc) begin
        off_q    <= off_in;
        wm1_q    <= wm1_in;
        hm1_q    <= hm1_in;
        stride_q <= stride_in;
      end
    end
  end

  assign run = run_q;

  // each new line resumes at the programmed first-pixel offset
  assert_line_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && col_end && !last) |=> (pos_q == off_q));
endmodule

// File: rtl/mxp_pixout.sv
module mxp_pixout #(
  parameter int unsigned AW    = 16,
  parameter int unsigned PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic             transp_in,
  input  logic [PIX_W-1:0] fg_in,
  input  logic [PIX_W-1:0] bg_in,
  input  logic             emit,
  input  logic             pix_bit,
  input  logic [AW-1:0]    pix_addr,
  output logic             px_we,
  output logic [AW-1:0]    px_addr,
  output logic [PIX_W-1:0] px_data,
  output logic             outv
);
  logic             transp_q;
  logic [PIX_W-1:0] fg_q, bg_q, data_d;
  logic             we_d;

  always_comb begin
    we_d   = emit && (pix_bit || !transp_q);
    data_d = pix_bit ? fg_q : bg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      transp_q <= 1'b0;
      fg_q     <= '0;
      bg_q     <= '0;
      px_we    <= 1'b0;
      px_addr  <= '0;
      px_data  <= '0;
      outv     <= 1'b0;
    end else begin
      if (start_acc) begin
        transp_q <= transp_in;
        fg_q     <= fg_in;
        bg_q     <= bg_in;
      end
      px_we <= we_d;
      outv  <= emit;
      if (emit) begin
        px_addr <= pix_addr;
        px_data <= data_d;
      end
    end
  end

  assert_transp_fg_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (px_we && transp_q) |-> (px_data == fg_q));
  assert_colour_choice_R8: assert property (@(posedge clk) disable iff (!rst_n)
    px_we |-> ((px_data == fg_q) || (px_data == bg_q)));
endmodule

// File: rtl/mono_expand.sv
module mono_expand
  import mxp_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DIM_W      = 10,
  parameter int unsigned PIX_W      = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              transp,
  input  logic              start_hi,
  input  logic [2:0]        start_bit,
  input  logic [AW-1:0]     dst_base,
  input  logic [AW-1:0]     dst_stride,
  input  logic [DIM_W-1:0]  width_m1,
  input  logic [DIM_W-1:0]  height_m1,
  input  logic [PIX_W-1:0]  fg_color,
  input  logic [PIX_W-1:0]  bg_color,
  input  logic              data_we,
  input  logic [WORD_W-1:0] data_in,
  output logic [7:0]        status,
  output logic              px_we,
  output logic [AW-1:0]     px_addr,
  output logic [PIX_W-1:0]  px_data
);
  logic              busy, start_acc, run, outv;
  logic              f_nempty, f_half, f_full, f_ovf, pop, emit, pix_bit;
  logic [WORD_W-1:0] f_rdata;
  logic [AW-1:0]     pix_addr;
  logic [POS_W-1:0]  off;

  always_comb begin
    busy      = run || outv;
    start_acc = start && !busy;
    off       = {start_hi, ~start_bit};
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_NEMP] = f_nempty;
    status[ST_HALF] = f_half;
    status[ST_FULL] = f_full;
    status[ST_OVF]  = f_ovf;
  end

  mxp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(data_we), .wdata(data_in),
    .pop(pop), .rdata(f_rdata), .clr_ovf(start_acc),
    .nempty(f_nempty), .half(f_half), .full(f_full), .ovf(f_ovf)
  );

  mxp_seq #(.AW(AW), .DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .off_in(off),
    .wm1_in(width_m1), .hm1_in(height_m1), .base_in(dst_base),
    .stride_in(dst_stride), .fifo_nempty(f_nempty), .fifo_rdata(f_rdata),
    .pop(pop), .emit(emit), .pix_bit(pix_bit), .pix_addr(pix_addr), .run(run)
  );

  mxp_pixout #(.AW(AW), .PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .transp_in(transp),
    .fg_in(fg_color), .bg_in(bg_color), .emit(emit), .pix_bit(pix_bit),
    .pix_addr(pix_addr), .px_we(px_we), .px_addr(px_addr), .px_data(px_data),
    .outv(outv)
  );

  assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run) |=> (run || outv));
endmodule

// File: tb/mono_expand_test.sv
module mono_expand_test;
  logic        clk, rst_n, start, transp, start_hi, data_we;
  logic [2:0]  start_bit;
  logic [15:0] dst_base, dst_stride, fg_color, bg_color, data_in, px_addr, px_data;
  logic [9:0]  width_m1, height_m1;
  logic [7:0]  status;
  logic        px_we;

  int nchk, nerr;
  logic [15:0] srcw [0:255];
  logic [15:0] fb   [0:1023];
  logic [15:0] xfb  [0:1023];
  int          nwr;
  logic        clr_fb;

  mono_expand uut (
    .clk(clk), .rst_n(rst_n), .start(start), .transp(transp), .start_hi(start_hi),
    .start_bit(start_bit), .dst_base(dst_base), .dst_stride(dst_stride),
    .width_m1(width_m1), .height_m1(height_m1), .fg_color(fg_color),
    .bg_color(bg_color), .data_we(data_we), .data_in(data_in), .status(status),
    .px_we(px_we), .px_addr(px_addr), .px_data(px_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] sentinel(int a);
    return 16'hA000 ^ 16'(a);
  endfunction

  always @(posedge clk) begin
    if (clr_fb) begin
      for (int i = 0; i < 1024; i++) fb[i] <= sentinel(i);
      nwr <= 0;
    end else if (px_we) begin
      fb[px_addr[9:0]] <= px_data;
      nwr <= nwr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // bit of pixel at (r,c): low byte first, bit 7 down within a byte
  function automatic int exp_bit(int r, int c, int off, int wpl);
    int p = off + c;
    int w = r * wpl + p / 16;
    int q = p % 16;
    int idx = (q < 8) ? 7 - q : 23 - q;
    return int'((srcw[w] >> idx) & 16'd1);
  endfunction

  task automatic push_word(input logic [15:0] w);
    @(negedge clk); data_we = 1'b1; data_in = w;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic run_job(input int base, input int stride, input int wm1, input int hm1,
                         input bit hi, input int sb, input bit tr, input int fgc,
                         input int bgc, input int first, input bit poke, input string tag);
    int off, wpl, total, sent, cyc, expw, bad, first_bad;
    off   = (hi ? 8 : 0) + (7 - sb);
    wpl   = (off + wm1 + 1 + 15) / 16;
    total = wpl * (hm1 + 1);
    if (first == 0) for (int i = 0; i < total; i++) srcw[i] = 16'($urandom);
    @(negedge clk); clr_fb = 1'b1;
    @(negedge clk); clr_fb = 1'b0;
    dst_base = 16'(base); dst_stride = 16'(stride); width_m1 = 10'(wm1);
    height_m1 = 10'(hm1); start_hi = hi; start_bit = 3'(sb); transp = tr;
    fg_color = 16'(fgc); bg_color = 16'(bgc); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(status[7] == 1'b1, "R10", {tag, " busy after start"}, int'(status[7]), 1);
    sent = first; cyc = 0;
    while ((sent < total || status[7]) && cyc < 5000) begin
      if (poke && cyc == 2) begin
        start = 1'b1; dst_base = 16'(base + 5); fg_color = ~16'(fgc);
        width_m1 = 10'(wm1 / 2);
      end else start = 1'b0;
      if (sent < total && !status[4] && ($urandom % 4 != 0)) begin
        data_we = 1'b1; data_in = srcw[sent]; sent++;
      end else data_we = 1'b0;
      @(negedge clk); cyc++;
    end
    data_we = 1'b0; start = 1'b0;
    check(cyc < 5000, "R10", {tag, " job completes"}, cyc, 0);
    for (int i = 0; i < 1024; i++) xfb[i] = sentinel(i);
    expw = 0;
    for (int r = 0; r <= hm1; r++)
      for (int c = 0; c <= wm1; c++) begin
        int a = (base + r * stride + c) % 1024;
        if (exp_bit(r, c, off, wpl) == 1) begin xfb[a] = 16'(fgc); expw++; end
        else if (!tr) begin xfb[a] = 16'(bgc); expw++; end
      end
    repeat (8) @(negedge clk);
    check(nwr == expw, tr ? "R9" : "R8", {tag, " write count"}, nwr, expw);
    check(status[7] == 1'b0, "R10", {tag, " idle after job"}, int'(status[7]), 0);
    bad = 0; first_bad = -1;
    for (int i = 0; i < 1024; i++)
      if (fb[i] !== xfb[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) first_bad = 0;
    // pixel values cover R5 (bit order), R6 (word per line), R7 (addressing)
    check(bad == 0, "R5/R6/R7", {tag, " frame contents"}, int'(fb[first_bad]),
          int'(xfb[first_bad]));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    nchk = 0; nerr = 0;
    rst_n = 1'b0; start = 1'b0; transp = 1'b0; start_hi = 1'b0; start_bit = 3'd7;
    data_we = 1'b0; data_in = '0; dst_base = '0; dst_stride = 16'd64;
    width_m1 = '0; height_m1 = '0; fg_color = '0; bg_color = '0; clr_fb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1", "status after reset", int'(status), 0);
    check(px_we == 1'b0, "R1", "no write after reset", int'(px_we), 0);

    // fill the FIFO while idle and watch the level bits
    for (int i = 0; i < 17; i++) srcw[i] = 16'($urandom);
    push_word(srcw[0]);
    check(status[6] == 1'b1, "R2", "not-empty with one word", int'(status[6]), 1);
    for (int i = 1; i < 7; i++) push_word(srcw[i]);
    check(status[5:4] == 2'b00, "R3", "level bits at 7 words", int'(status[5:4]), 0);
    push_word(srcw[7]);
    check(status[5:4] == 2'b10, "R3", "level bits at 8 words", int'(status[5:4]), 2);
    for (int i = 8; i < 15; i++) push_word(srcw[i]);
    check(status[5:4] == 2'b10, "R3", "level bits at 15 words", int'(status[5:4]), 2);
    push_word(srcw[15]);
    check(status[5:4] == 2'b11, "R3", "level bits at 16 words", int'(status[5:4]), 3);
    check(status[3] == 1'b0, "R4", "no overflow yet", int'(status[3]), 0);
    push_word(16'hDEAD);
    check(status[3] == 1'b1, "R4", "overflow flag set", int'(status[3]), 1);
    check(status[4] == 1'b1, "R4", "still full after drop", int'(status[4]), 1);
    @(negedge clk);
    check(status[3] == 1'b1, "R4", "overflow flag sticky", int'(status[3]), 1);

    // job consuming exactly the 16 stored words; dropped word must not appear
    run_job(0, 64, 31, 7, 1'b0, 7, 1'b0, 16'h1234, 16'h00F0, 16, 1'b0, "prefilled");
    check(status[3] == 1'b0, "R4", "overflow cleared by start", int'(status[3]), 0);
    check(status[6] == 1'b0, "R4", "FIFO empty after job", int'(status[6]), 0);

    // directed corners
    run_job(10, 64, 0, 0, 1'b0, 7, 1'b0, 16'hF00F, 16'h0FF0, 0, 1'b0, "single pixel R8");
    run_job(20, 64, 16, 3, 1'b1, 0, 1'b0, 16'h7777, 16'h1111, 0, 1'b0, "offset 15 R6");
    run_job(30, 64, 39, 5, 1'b0, 3, 1'b1, 16'hBEEF, 16'h0000, 0, 1'b0, "transparent R9");
    run_job(5, 64, 15, 2, 1'b1, 7, 1'b1, 16'h4242, 16'h2424, 0, 1'b0, "high byte start R5");
    run_job(40, 64, 35, 7, 1'b0, 5, 1'b0, 16'hC0DE, 16'h0ACE, 0, 1'b1, "restart ignored R11");

    // random jobs
    for (int k = 0; k < 24; k++) begin
      run_job(int'($urandom % 256), 64, int'($urandom % 40), int'($urandom % 8),
              1'($urandom), int'($urandom % 8), 1'($urandom), int'($urandom % 65536),
              int'($urandom % 65536), 0, 1'b0, "random");
    end
    summary();
  end
endmodule